// File: doc/BRIEF.md
# Zero-Crossing Phase and Frequency Meter

The block times the interval between zero-crossing events on two lines. One line carries crossings of a voltage waveform and the other carries crossings of a current waveform. Both arrive as single-cycle pulses that are already synchronous to the block clock. A mode input picks the measurement type:

- **Frequency mode** times one full period of the voltage signal, from one voltage crossing to the next.
- **Phase mode** times the lag from a voltage crossing to the following current crossing.

Elapsed time is counted in ticks of a programmable prescaler. A timer counts these ticks up to a programmable period and then wraps. Each wrap adds one to an overflow tally. At the stopping crossing, the block captures the timer value and the tally and raises a done flag. Turning the counts into hertz or degrees is left to the consumer.

To use the block, a controller sets the mode, the prescale divisor and the timer period, then pulses the start input. The block latches the settings, clears its results and waits for a voltage crossing to begin timing.

Top module: `zc_meter`

## Requirements
- R1: While reset is asserted, and after it is released, `done_o`, `timeout_o`, `cap_count_o` and `ovf_count_o` are all zero.
- R2: A `start_i` pulse clears `done_o`, `timeout_o`, `cap_count_o` and `ovf_count_o` on the next clock edge. The same edge latches `mode_i`, `presc_i` and `period_i`; later changes to these inputs do not affect the measurement in progress.
- R3: With `mode_i`=0 (frequency), the first voltage crossing after start begins timing and the second one ends it. Current crossings have no effect in this mode.
- R4: With `mode_i`=1 (phase), a voltage crossing begins timing and the next current crossing ends it. Current crossings seen before the voltage crossing are ignored, and so are further voltage crossings while timing.
- R5: Let D be the number of clock cycles from the starting crossing to the stopping crossing, and let T = floor((D-1)/(P+1)), where P is the latched prescale value. The timer wraps after reaching the latched period N. The captured count is T mod (N+1) and the tally is T div (N+1).
- R6: The overflow tally saturates at 2^OVF_W-1 (15 by default). A timer wrap that occurs while the tally is already saturated sets `timeout_o` instead of wrapping the tally.
- R7: `done_o` rises on the clock edge that samples the stopping crossing. It then stays high, with `cap_count_o`, `ovf_count_o` and `timeout_o` unchanged, until the next start.
- R8: Crossings that arrive while the block is idle (before any start) or already done change none of the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Single-cycle request to begin a new measurement |
| mode_i | input | 1 | 0 = frequency measurement, 1 = phase measurement |
| presc_i | input | PRE_W | Prescale value P; the timer advances once every P+1 cycles |
| period_i | input | CNT_W | Timer period N; the timer wraps after reaching N |
| v_zc_i | input | 1 | Voltage zero-crossing pulse |
| i_zc_i | input | 1 | Current zero-crossing pulse |
| cap_count_o | output | CNT_W | Timer value captured at the stopping crossing |
| ovf_count_o | output | OVF_W | Timer wraps counted during the measurement |
| done_o | output | 1 | Measurement complete |
| timeout_o | output | 1 | Overflow tally saturated during the measurement |

## Verification
The hardest case to reach is saturation of the overflow tally. It needs more timer wraps than the tally can hold, so the stimulus uses a prescale of zero and a period of zero, which makes every clock cycle a wrap. A crossing gap of thirty cycles then drives the tally past its limit. Crossings of the ignored kind are inserted before the start crossing and in the middle of every measured interval. This shows that the stop decision follows both the source line and the order in which crossings arrive.

// File: rtl/zc_pkg.sv
package zc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2,
        ST_DONE  = 2'd3
    } zc_state_e;

    typedef enum logic {
        MODE_FREQ  = 1'b0,
        MODE_PHASE = 1'b1
    } zc_mode_e;

endpackage

// File: rtl/zc_prescaler.sv
module zc_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_clr,
    input  logic             run,
    input  logic [PRE_W-1:0] divide,
    output logic             tick
);
    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_regs_t;

    pre_regs_t r_q, r_d;

    assign tick = run && (r_q.cnt == divide);

    always_comb begin
        r_d = r_q;
        if (hold_clr) begin
            r_d.cnt = '0;
        end else if (run) begin
            r_d.cnt = tick ? '0 : r_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/zc_timer.sv
module zc_timer #(
    parameter int CNT_W = 16,
    parameter int OVF_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_clr,
    input  logic             tick,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count,
    output logic [OVF_W-1:0] tally,
    output logic             sat_hit
);
    localparam logic [OVF_W-1:0] TALLY_MAX = {OVF_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [OVF_W-1:0] tally;
        logic             sat_hit;
    } tmr_regs_t;

    tmr_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (hold_clr) begin
            r_d = '0;
        end else if (tick) begin
            if (r_q.count == period) begin
                r_d.count = '0;
                if (r_q.tally == TALLY_MAX) r_d.sat_hit = 1'b1;
                else                        r_d.tally   = r_q.tally + 1'b1;
            end else begin
                r_d.count = r_q.count + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign count   = r_q.count;
    assign tally   = r_q.tally;
    assign sat_hit = r_q.sat_hit;
endmodule

// File: rtl/zc_seq.sv
module zc_seq
    import zc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      mode_in,
    input  logic      v_zc,
    input  logic      i_zc,
    output zc_state_e state,
    output logic      stop_evt
);
    typedef struct packed {
        zc_state_e st;
        zc_mode_e  mode;
    } seq_regs_t;

    seq_regs_t r_q, r_d;
    logic      stop_src;

    // Stop source depends on the latched mode: the second voltage crossing
    // in frequency mode, the first current crossing in phase mode.
    assign stop_src = (r_q.mode == MODE_PHASE) ? i_zc : v_zc;
    assign stop_evt = !start && (r_q.st == ST_RUN) && stop_src;

    always_comb begin
        r_d = r_q;
        if (start) begin
            r_d.st   = ST_ARMED;
            r_d.mode = zc_mode_e'(mode_in);
        end else begin
            case (r_q.st)
                ST_ARMED: if (v_zc) r_d.st = ST_RUN;
                ST_RUN:   if (stop_src) r_d.st = ST_DONE;
                default:  r_d.st = r_q.st;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, mode: MODE_FREQ};
        else        r_q <= r_d;
    end

    assign state = r_q.st;
endmodule

// File: rtl/zc_meter.sv
module zc_meter
    import zc_pkg::*;
#(
    parameter int PRE_W = 8,
    parameter int CNT_W = 16,
    parameter int OVF_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             mode_i,
    input  logic [PRE_W-1:0] presc_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic             v_zc_i,
    input  logic             i_zc_i,
    output logic [CNT_W-1:0] cap_count_o,
    output logic [OVF_W-1:0] ovf_count_o,
    output logic             done_o,
    output logic             timeout_o
);
    typedef struct packed {
        logic [PRE_W-1:0] presc;
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] cap;
        logic [OVF_W-1:0] ovf;
        logic             done;
        logic             tmo;
    } top_regs_t;

    top_regs_t r_q, r_d;

    zc_state_e        state;
    logic             stop_evt;
    logic             running;
    logic             tick;
    logic [CNT_W-1:0] t_count;
    logic [OVF_W-1:0] t_tally;
    logic             t_sat;

    zc_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_i),
        .mode_in  (mode_i),
        .v_zc     (v_zc_i),
        .i_zc     (i_zc_i),
        .state    (state),
        .stop_evt (stop_evt)
    );

    assign running = (state == ST_RUN);

    zc_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_clr (!running),
        .run      (running),
        .divide   (r_q.presc),
        .tick     (tick)
    );

    zc_timer #(.CNT_W(CNT_W), .OVF_W(OVF_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_clr (start_i || (state == ST_ARMED)),
        .tick     (tick),
        .period   (r_q.period),
        .count    (t_count),
        .tally    (t_tally),
        .sat_hit  (t_sat)
    );

    always_comb begin
        r_d = r_q;
        if (start_i) begin
            r_d.presc  = presc_i;
            r_d.period = period_i;
            r_d.cap    = '0;
            r_d.ovf    = '0;
            r_d.done   = 1'b0;
            r_d.tmo    = 1'b0;
        end else if (stop_evt) begin
            r_d.cap  = t_count;
            r_d.ovf  = t_tally;
            r_d.tmo  = t_sat;
            r_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cap_count_o = r_q.cap;
    assign ovf_count_o = r_q.ovf;
    assign done_o      = r_q.done;
    assign timeout_o   = r_q.tmo;
endmodule

// File: rtl/zc_meter_chk.sv
module zc_meter_chk #(
    parameter int CNT_W = 16,
    parameter int OVF_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             v_zc_i,
    input logic             i_zc_i,
    input logic [CNT_W-1:0] cap_count_o,
    input logic [OVF_W-1:0] ovf_count_o,
    input logic             done_o,
    input logic             timeout_o
);
    localparam logic [OVF_W-1:0] OVF_TOP = {OVF_W{1'b1}};

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!done_o && !timeout_o && cap_count_o == '0 && ovf_count_o == '0));

    a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!done_o && !timeout_o && cap_count_o == '0 && ovf_count_o == '0));

    a_r6_timeout_saturated: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> (ovf_count_o == OVF_TOP));

    a_r6_tally_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> (ovf_count_o >= $past(ovf_count_o)));

    a_r7_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(cap_count_o) && $stable(ovf_count_o)
                                  && $stable(timeout_o)));

    a_r8_done_ignores_crossings: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i && (v_zc_i || i_zc_i)) |=> (done_o && $stable(cap_count_o)));
endmodule

bind zc_meter zc_meter_chk #(.CNT_W(CNT_W), .OVF_W(OVF_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .v_zc_i      (v_zc_i),
    .i_zc_i      (i_zc_i),
    .cap_count_o (cap_count_o),
    .ovf_count_o (ovf_count_o),
    .done_o      (done_o),
    .timeout_o   (timeout_o)
);

// File: tb/zc_meter_tb_top.sv
module zc_meter_tb_top;
    localparam int PRE_W = 8;
    localparam int CNT_W = 16;
    localparam int OVF_W = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             mode_i = 1'b0;
    logic [PRE_W-1:0] presc_i = '0;
    logic [CNT_W-1:0] period_i = '0;
    logic             v_zc_i = 1'b0;
    logic             i_zc_i = 1'b0;
    logic [CNT_W-1:0] cap_count_o;
    logic [OVF_W-1:0] ovf_count_o;
    logic             done_o;
    logic             timeout_o;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    zc_meter #(.PRE_W(PRE_W), .CNT_W(CNT_W), .OVF_W(OVF_W)) dut_i (.*);

    typedef struct packed {
        logic             mode;
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] per;
        logic [15:0]      gap;
        logic [CNT_W-1:0] cap;
        logic [OVF_W-1:0] ovf;
        logic             tmo;
    } vec_t;

    // mode, P, N, gap D, expected cap = T mod (N+1), tally = T div (N+1), timeout
    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'd0, 16'd100,  16'd11, 16'd10, 4'd0,  1'b0},
        '{1'b0, 8'd3, 16'd100,  16'd41, 16'd10, 4'd0,  1'b0},
        '{1'b1, 8'd1, 16'd4,    16'd24, 16'd1,  4'd2,  1'b0},
        '{1'b1, 8'd0, 16'd0,    16'd30, 16'd0,  4'd15, 1'b1},
        '{1'b0, 8'd2, 16'd9,    16'd35, 16'd1,  4'd1,  1'b0},
        '{1'b1, 8'd0, 16'd1000, 16'd1,  16'd0,  4'd0,  1'b0}
    };

    task automatic check(input string req, input string what, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start(input logic m, input int p, input int n);
        mode_i = m; presc_i = PRE_W'(p); period_i = CNT_W'(n);
        start_i = 1'b1; cyc(1); start_i = 1'b0;
    endtask

    task automatic pulse_v();
        v_zc_i = 1'b1; cyc(1); v_zc_i = 1'b0;
    endtask

    task automatic pulse_i();
        i_zc_i = 1'b1; cyc(1); i_zc_i = 1'b0;
    endtask

    // Start crossing at edge k, stop crossing at edge k+gap, with an
    // ignored-kind crossing in between when the gap allows it.
    task automatic measure(input logic m, input int gap);
        pulse_v();
        if (gap >= 4) begin
            int h = gap / 2;
            cyc(h - 1);
            if (m) pulse_v(); else pulse_i();
            cyc(gap - h - 1);
        end else begin
            cyc(gap - 1);
        end
        if (m) pulse_i(); else pulse_v();
    endtask

    initial begin
        cyc(3);
        check("R1", "done in reset", done_o, 0);
        check("R1", "cap in reset", cap_count_o, 0);
        rst_n = 1'b1;
        cyc(2);
        check("R1", "timeout after reset", timeout_o, 0);
        check("R1", "tally after reset", ovf_count_o, 0);

        // R8: crossings while idle
        pulse_v(); cyc(2); pulse_i(); pulse_v(); cyc(3);
        check("R8", "done after idle crossings", done_o, 0);
        check("R8", "cap after idle crossings", cap_count_o, 0);

        // Vector table: R3, R4, R5, R6, R7
        for (int k = 0; k < NV; k++) begin
            pulse_start(VECS[k].mode, int'(VECS[k].pre), int'(VECS[k].per));
            check("R2", "done cleared by start", done_o, 0);
            cyc(2);
            pulse_i();   // current crossing before start crossing: ignored (R4)
            cyc(2);
            check("R4", "no stop before voltage crossing", done_o, 0);
            measure(VECS[k].mode, int'(VECS[k].gap));
            check(VECS[k].mode ? "R4" : "R3", "done at stop", done_o, 1);
            check("R5", "captured count", cap_count_o, int'(VECS[k].cap));
            check("R5", "overflow tally", ovf_count_o, int'(VECS[k].ovf));
            check("R6", "timeout flag", timeout_o, int'(VECS[k].tmo));
        end

        // R7 / R8: crossings after done leave results stable (last vector: cap 0)
        cyc(3);
        pulse_v(); pulse_i(); cyc(1); pulse_v(); cyc(3);
        check("R7", "done held", done_o, 1);
        check("R8", "cap after done crossings", cap_count_o, 0);
        check("R8", "tally after done crossings", ovf_count_o, 0);

        // R6 result remains until start, then R2 clears everything
        pulse_start(1'b1, 0, 0);
        measure(1'b1, 30);
        cyc(4);
        check("R7", "timeout held", timeout_o, 1);
        pulse_start(1'b0, 0, 100);
        check("R2", "timeout cleared by start", timeout_o, 0);
        check("R2", "tally cleared by start", ovf_count_o, 0);

        // R2: settings latched at start; later changes ignored. T = 5 with P=0.
        presc_i = 8'd7; period_i = 16'd2; mode_i = 1'b1;
        cyc(2);
        measure(1'b0, 6);
        check("R2", "latched settings count", cap_count_o, 5);
        check("R3", "frequency stop with latched mode", done_o, 1);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule